// File: doc/BRIEF.md
# Programmable External Bus Strobe Timer

This block times the control strobes of one external memory space. Software loads a 16-bit control word that places each strobe edge at its own offset, counted in memory-clock (MCLK) periods: the cycle start delay, the point where the read or write strobe asserts, the point where address output ends, the point where the read strobe negates, and the point where the whole cycle ends. When an access is requested and the block is idle, it runs a cycle counter and drives a bus-start pulse, an address-valid window, an active-low read strobe, an active-low write strobe and a cycle-done pulse at the programmed counts.

Some field codes are prohibited, and some field orderings must hold. The start delay is also limited by the MCLK/SYSCLK ratio, which is captured together with each register write. When an access begins with an illegal setting, the block raises a configuration error flag and runs the access with legalised values. The timing of an access is frozen when the access is accepted, so later register writes only affect later accesses.

Top module: `strobe_timer`

## Requirements
- R1: After reset the control register reads 16'hEFFC and all strobes are idle: bus_start, addr_valid and cycle_done are 0, and rd_en_n and wr_en_n are 1.
- R2: The control word has this layout: read-negate count in bits 15:11, cycle-end count in bits 10:6, address-end count in bits 5:4, strobe-assert count in bits 3:2 and start delay in bits 1:0. A write sets reg_rdata to the written value from the next cycle. ratio_sel is captured only on a register write (00 = ratio 1, 01 = ratio 2, 10 and 11 = higher ratios), and changing it at any other time has no effect.
- R3: Take t = 0 as the first cycle after the access is accepted. bus_start is 1 only at t = start, and addr_valid is 1 for start ≤ t ≤ start + address-end.
- R4: On a read access (acc_read = 1), rd_en_n is 0 for strobe-assert ≤ t < read-negate and wr_en_n stays 1.
- R5: On a write access (acc_read = 0), wr_en_n is 0 for strobe-assert ≤ t < cycle-end and rd_en_n stays 1.
- R6: cycle_done is 1 for exactly one cycle, at t = cycle-end, and the access finishes in that cycle.
- R7: A request is accepted only when no access is running. A request held during an access, including the cycle_done cycle, is ignored and starts no access.
- R8: Legalisation works as follows. The start delay is clamped to 0 at ratio 1 and to 1 at ratio 2. Cycle-end and read-negate codes below 4 become 4. Cycle-end is raised to at least start + address-end. Read-negate is lowered to at most cycle-end.
- R9: cfg_err is set when an access is accepted with a raw setting that breaks any of these rules: start above the ratio limit, cycle-end < 4, read-negate < 4, read-negate > cycle-end, or cycle-end < start + address-end. It is cleared when an access is accepted with a legal setting, and it holds its value between accepts.
- R10: A register write made during an access, or in the cycle the access is accepted, does not change that access. The next access uses the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock (MCLK) |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control register write data |
| ratio_sel | input | 2 | MCLK/SYSCLK ratio code, captured on writes |
| reg_rdata | output | 16 | Control register read data |
| acc_req | input | 1 | Access request |
| acc_read | input | 1 | 1 = read access, 0 = write access |
| bus_start | output | 1 | Bus cycle start pulse |
| addr_valid | output | 1 | Address output window |
| rd_en_n | output | 1 | Read strobe, active low |
| wr_en_n | output | 1 | Write strobe, active low |
| cycle_done | output | 1 | Cycle end pulse |
| cfg_err | output | 1 | Illegal configuration seen at last accept |

## Verification
Two events can fall in the same cycle. The first is a register write in the same cycle that a request is accepted. The bench drives reg_we and acc_req on the same edge and expects the access to follow the old control word and the next access to follow the new one. The second is a request raised in the cycle_done cycle. The scoreboard then expects one idle cycle, with no bus_start, no address window and both strobes high, before anything else happens.

// File: rtl/strobe_timer_pkg.sv
package strobe_timer_pkg;

    localparam int CTRL_W  = 16;
    localparam int CNT_W   = 5;
    localparam int SHORT_W = 2;
    localparam logic [CNT_W-1:0] LONG_MIN = CNT_W'(4);

    typedef enum logic [1:0] {
        RATIO_X1 = 2'b00,
        RATIO_X2 = 2'b01,
        RATIO_X4 = 2'b10,
        RATIO_X8 = 2'b11
    } ratio_e;

    // Control word, MSB first
    typedef struct packed {
        logic [CNT_W-1:0]   neg_rd;
        logic [CNT_W-1:0]   end_cyc;
        logic [SHORT_W-1:0] end_addr;
        logic [SHORT_W-1:0] on_strobe;
        logic [SHORT_W-1:0] dly_start;
    } ctrl_t;

    // Legalised absolute counts
    typedef struct packed {
        logic [CNT_W-1:0] t_start;
        logic [CNT_W-1:0] t_addr_end;
        logic [CNT_W-1:0] t_strobe;
        logic [CNT_W-1:0] t_rd_off;
        logic [CNT_W-1:0] t_end;
    } timing_t;

    typedef struct packed {
        logic bus_start;
        logic addr_valid;
        logic rd_n;
        logic wr_n;
        logic done;
    } strobe_t;

    function automatic logic [SHORT_W-1:0] start_limit(ratio_e r);
        case (r)
            RATIO_X1: return SHORT_W'(0);
            RATIO_X2: return SHORT_W'(1);
            default:  return SHORT_W'(3);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] widen(logic [SHORT_W-1:0] v);
        return {{(CNT_W-SHORT_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/strobe_timer_cfg.sv
module strobe_timer_cfg
    import strobe_timer_pkg::*;
#(
    parameter logic [CTRL_W-1:0] RESET_VAL = 16'hEFFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic [1:0]        ratio_in,
    output ctrl_t             ctrl_q,
    output ratio_e            ratio_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= ctrl_t'(RESET_VAL);
            ratio_q <= RATIO_X1;
        end else if (wr_en) begin
            ctrl_q  <= ctrl_t'(wr_data);
            ratio_q <= ratio_e'(ratio_in);
        end
    end

endmodule

// File: rtl/strobe_timer_legal.sv
module strobe_timer_legal
    import strobe_timer_pkg::*;
(
    input  ctrl_t   ctrl,
    input  ratio_e  ratio,
    output timing_t tim,
    output logic    bad
);

    logic [SHORT_W-1:0] lim;
    logic [SHORT_W-1:0] st;
    logic [CNT_W-1:0]   span_raw;
    logic [CNT_W-1:0]   span;
    logic [CNT_W-1:0]   e_min;
    logic [CNT_W-1:0]   e_fix;
    logic [CNT_W-1:0]   r_min;
    logic [CNT_W-1:0]   r_fix;

    always_comb begin
        lim      = start_limit(ratio);
        st       = (ctrl.dly_start > lim) ? lim : ctrl.dly_start;
        span_raw = widen(ctrl.dly_start) + widen(ctrl.end_addr);
        span     = widen(st) + widen(ctrl.end_addr);
        // cycle end: at least the minimum code, then at least the address span
        e_min    = (ctrl.end_cyc < LONG_MIN) ? LONG_MIN : ctrl.end_cyc;
        e_fix    = (e_min < span) ? span : e_min;
        // read negate: at least the minimum code, at most the cycle end
        r_min    = (ctrl.neg_rd < LONG_MIN) ? LONG_MIN : ctrl.neg_rd;
        r_fix    = (r_min > e_fix) ? e_fix : r_min;

        bad = (ctrl.dly_start > lim)
            | (ctrl.end_cyc < LONG_MIN)
            | (ctrl.neg_rd < LONG_MIN)
            | (ctrl.neg_rd > ctrl.end_cyc)
            | (ctrl.end_cyc < span_raw);

        tim.t_start    = widen(st);
        tim.t_addr_end = span;
        tim.t_strobe   = widen(ctrl.on_strobe);
        tim.t_rd_off   = r_fix;
        tim.t_end      = e_fix;
    end

endmodule

// File: rtl/strobe_timer_seq.sv
module strobe_timer_seq
    import strobe_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             rd_in,
    input  timing_t          tim_in,
    input  logic             bad_in,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output timing_t          tim_q,
    output logic             rd_q,
    output logic             err
);

    logic accept;
    assign accept = req && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            tim_q <= '0;
            rd_q  <= 1'b0;
            err   <= 1'b0;
        end else if (accept) begin
            busy  <= 1'b1;
            cnt   <= '0;
            tim_q <= tim_in;
            rd_q  <= rd_in;
            err   <= bad_in;
        end else if (busy) begin
            if (cnt == tim_q.t_end) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/strobe_timer_out.sv
module strobe_timer_out
    import strobe_timer_pkg::*;
(
    input  logic             busy,
    input  logic [CNT_W-1:0] cnt,
    input  timing_t          tim,
    input  logic             rd,
    output strobe_t          stb
);

    logic in_strobe;

    always_comb begin
        in_strobe      = busy && (cnt >= tim.t_strobe);
        stb.bus_start  = busy && (cnt == tim.t_start);
        stb.addr_valid = busy && (cnt >= tim.t_start) && (cnt <= tim.t_addr_end);
        stb.rd_n       = !(in_strobe && rd && (cnt < tim.t_rd_off));
        stb.wr_n       = !(in_strobe && !rd && (cnt < tim.t_end));
        stb.done       = busy && (cnt == tim.t_end);
    end

endmodule

// File: rtl/strobe_timer.sv
module strobe_timer
    import strobe_timer_pkg::*;
#(
    parameter logic [15:0] RESET_VAL = 16'hEFFC
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [15:0] reg_wdata,
    input  logic [1:0]  ratio_sel,
    output logic [15:0] reg_rdata,
    input  logic        acc_req,
    input  logic        acc_read,
    output logic        bus_start,
    output logic        addr_valid,
    output logic        rd_en_n,
    output logic        wr_en_n,
    output logic        cycle_done,
    output logic        cfg_err
);

    ctrl_t            ctrl_q;
    ratio_e           ratio_q;
    timing_t          tim_now;
    timing_t          tim_run;
    logic             bad_now;
    logic             busy;
    logic             rd_run;
    logic [CNT_W-1:0] cnt;
    strobe_t          stb;

    strobe_timer_cfg #(.RESET_VAL(RESET_VAL)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_we),
        .wr_data  (reg_wdata),
        .ratio_in (ratio_sel),
        .ctrl_q   (ctrl_q),
        .ratio_q  (ratio_q)
    );

    strobe_timer_legal u_legal (
        .ctrl  (ctrl_q),
        .ratio (ratio_q),
        .tim   (tim_now),
        .bad   (bad_now)
    );

    strobe_timer_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .req    (acc_req),
        .rd_in  (acc_read),
        .tim_in (tim_now),
        .bad_in (bad_now),
        .busy   (busy),
        .cnt    (cnt),
        .tim_q  (tim_run),
        .rd_q   (rd_run),
        .err    (cfg_err)
    );

    strobe_timer_out u_out (
        .busy (busy),
        .cnt  (cnt),
        .tim  (tim_run),
        .rd   (rd_run),
        .stb  (stb)
    );

    assign reg_rdata  = ctrl_q;
    assign bus_start  = stb.bus_start;
    assign addr_valid = stb.addr_valid;
    assign rd_en_n    = stb.rd_n;
    assign wr_en_n    = stb.wr_n;
    assign cycle_done = stb.done;

endmodule

// File: rtl/strobe_timer_chk.sv
module strobe_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic [15:0] reg_wdata,
    input logic [1:0]  ratio_sel,
    input logic [15:0] reg_rdata,
    input logic        acc_req,
    input logic        acc_read,
    input logic        bus_start,
    input logic        addr_valid,
    input logic        rd_en_n,
    input logic        wr_en_n,
    input logic        cycle_done,
    input logic        cfg_err
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (reg_rdata == 16'hEFFC) && rd_en_n && wr_en_n && !cycle_done);

    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (reg_rdata == $past(reg_wdata)));

    p_start_in_window_r3: assert property (@(posedge clk) disable iff (rst)
        bus_start |-> addr_valid);

    p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        !(!rd_en_n && !wr_en_n));

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        cycle_done |=> !cycle_done);

    p_idle_after_done_r7: assert property (@(posedge clk) disable iff (rst)
        cycle_done |=> (!bus_start && !addr_valid && rd_en_n && wr_en_n));

endmodule

bind strobe_timer strobe_timer_chk u_chk (.*);

// File: tb/strobe_timer_test.sv
`timescale 1ns/1ps
module strobe_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [1:0]  ratio_sel = 2'b00;
    logic        acc_req = 1'b0;
    logic        acc_read = 1'b0;
    logic [15:0] reg_rdata;
    logic        bus_start, addr_valid, rd_en_n, wr_en_n, cycle_done, cfg_err;

    strobe_timer uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .ratio_sel(ratio_sel), .reg_rdata(reg_rdata), .acc_req(acc_req),
        .acc_read(acc_read), .bus_start(bus_start), .addr_valid(addr_valid),
        .rd_en_n(rd_en_n), .wr_en_n(wr_en_n), .cycle_done(cycle_done),
        .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic bs, av, rn, wn, dn, er;
    } exp_t;

    exp_t        q[$];
    int          total = 0;
    int          bad = 0;
    logic [15:0] m_ctrl = 16'hEFFC;
    logic [1:0]  m_ratio = 2'b00;
    logic        last_err = 1'b0;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp,
                       input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pack(int rn, int ce, int ae, int ea, int st);
        return {rn[4:0], ce[4:0], ae[1:0], ea[1:0], st[1:0]};
    endfunction

    // Expected timing from the requirements (R8, R9)
    task automatic model(input logic [15:0] c, input logic [1:0] r,
                         output int s, output int a, output int ea, output int rn,
                         output int ce, output bit er);
        int st, ae, rce, rrn, lim;
        st  = int'(c[1:0]);
        ea  = int'(c[3:2]);
        ae  = int'(c[5:4]);
        rce = int'(c[10:6]);
        rrn = int'(c[15:11]);
        lim = (r == 2'b00) ? 0 : (r == 2'b01) ? 1 : 3;
        er  = (st > lim) || (rce < 4) || (rrn < 4) || (rrn > rce) || (rce < st + ae);
        s   = (st > lim) ? lim : st;
        a   = s + ae;
        ce  = (rce < 4) ? 4 : rce;
        if (ce < a) ce = a;
        rn  = (rrn < 4) ? 4 : rrn;
        if (rn > ce) rn = ce;
    endtask

    // Monitor: pops one expected item per access cycle, else checks idle
    always @(negedge clk) begin
        if (!rst) begin
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk("R3", 16'(bus_start),  16'(e.bs), "bus_start");
                chk("R3", 16'(addr_valid), 16'(e.av), "addr_valid");
                chk("R4", 16'(rd_en_n),    16'(e.rn), "rd_en_n");
                chk("R5", 16'(wr_en_n),    16'(e.wn), "wr_en_n");
                chk("R6", 16'(cycle_done), 16'(e.dn), "cycle_done");
                chk("R9", 16'(cfg_err),    16'(e.er), "cfg_err");
                last_err = e.er;
            end else begin
                chk("R7", {11'd0, bus_start, addr_valid, rd_en_n, wr_en_n, cycle_done},
                    16'b0000_0000_0000_0110, "idle strobes");
                chk("R9", 16'(cfg_err), 16'(last_err), "cfg_err hold");
            end
        end
    end

    task automatic wr(input logic [15:0] v, input logic [1:0] r);
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = v; ratio_sel = r;
        @(posedge clk); #1;
        reg_we = 1'b0;
        m_ctrl = v; m_ratio = r;
        @(negedge clk);
        chk("R2", reg_rdata, v, "readback");
    endtask

    // Driver: wr_at = -2 writes in the accept cycle, >= 0 writes at count t
    task automatic do_access(input bit rd, input int poke_at, input int wr_at,
                             input logic [15:0] wval);
        int s, a, ea, rn, ce;
        bit er;
        model(m_ctrl, m_ratio, s, a, ea, rn, ce, er);
        @(negedge clk);
        acc_req = 1'b1; acc_read = rd;
        if (wr_at == -2) begin reg_we = 1'b1; reg_wdata = wval; end
        @(posedge clk); #1;
        acc_req = 1'b0;
        if (wr_at == -2) begin reg_we = 1'b0; m_ctrl = wval; m_ratio = ratio_sel; end
        for (int t = 0; t <= ce; t++) begin
            exp_t e;
            e.bs = (t == s);
            e.av = (t >= s) && (t <= a);
            e.rn = !(rd && t >= ea && t < rn);
            e.wn = !(!rd && t >= ea && t < ce);
            e.dn = (t == ce);
            e.er = er;
            q.push_back(e);
        end
        for (int t = 0; t <= ce; t++) begin
            if (t == poke_at) acc_req = 1'b1;
            if (t == wr_at) begin reg_we = 1'b1; reg_wdata = wval; end
            @(posedge clk); #1;
            acc_req = 1'b0;
            if (t == wr_at) begin reg_we = 1'b0; m_ctrl = wval; m_ratio = ratio_sel; end
        end
        repeat (2) @(posedge clk);
    endtask

    initial begin
        #3_000_000;
        bad++;
        $display("FAIL R6 watchdog: actual=hang expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1", reg_rdata, 16'hEFFC, "reset value");
        // R4/R5 default timing
        do_access(1'b1, -1, -1, 16'h0);
        do_access(1'b0, -1, -1, 16'h0);
        // R3 legal custom timing
        wr(pack(6, 8, 2, 1, 1), 2'b01);
        do_access(1'b1, -1, -1, 16'h0);
        do_access(1'b0, -1, -1, 16'h0);
        // R8 start over ratio-2 limit
        wr(pack(6, 8, 0, 0, 3), 2'b01);
        do_access(1'b1, -1, -1, 16'h0);
        // R8 short codes raised to 4
        wr(pack(1, 2, 1, 2, 0), 2'b00);
        do_access(1'b0, -1, -1, 16'h0);
        // R8 read negate past cycle end
        wr(pack(20, 10, 1, 1, 0), 2'b00);
        do_access(1'b1, -1, -1, 16'h0);
        // R8 cycle end below start + address end
        wr(pack(4, 5, 3, 0, 3), 2'b10);
        do_access(1'b1, -1, -1, 16'h0);
        // R9 clear on legal, R7 requests during run and done cycle
        wr(pack(5, 7, 1, 0, 0), 2'b00);
        do_access(1'b1, 2, -1, 16'h0);
        do_access(1'b0, 7, -1, 16'h0);
        // R2 ratio captured only on write
        wr(pack(9, 12, 2, 3, 3), 2'b11);
        @(negedge clk); ratio_sel = 2'b00;
        do_access(1'b1, -1, -1, 16'h0);
        // R10 write during run, then in accept cycle
        do_access(1'b0, -1, 1, pack(6, 9, 1, 1, 0));
        chk("R10", reg_rdata, pack(6, 9, 1, 1, 0), "write during run");
        do_access(1'b0, -1, -1, 16'h0);
        do_access(1'b1, -1, -2, pack(8, 8, 0, 1, 0));
        do_access(1'b1, -1, -1, 16'h0);
        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule